// File: doc/BRIEF.md
# ATAPI Device Packet-Command Engine

This block is the device end of an ATA task file that runs the PIO packet protocol. A host reaches it over a small register bus with separate read and write strobes. Byte-wide registers cover error/feature, sector count (interrupt reason), LBA low/mid/high, device, status/command and the alternate status. A 16-bit data port carries packet words and reply words. The engine accepts three commands: device reset, SET FEATURES (transfer mode) and PACKET. Every other opcode is rejected with the abort encoding.

A PACKET command takes the host through a command phase of six data-port writes and then a busy period. After that it either completes at once or enters a data-in phase that streams a fixed 12-byte identification reply. A second busy period and a status phase follow. The first packet after any reset ends with a unit-attention error. An interrupt line is raised at the end of each phase and is cleared by reading the status register. Reading the alternate status register does not clear it.

Top module: `atapi_pkt_engine`

## Requirements
- R1: Both the reset input and command 0x08 leave status 0x00, error 0x01, count 0x01, LBA0 0x01, LBA1 0x14, LBA2 0xEB and device 0x00. The data port reads 0xFFFF and INTRQ stays low.
- R2: Command 0xEF with feature 0x03 ends with status 0x50, error 0x00, count keeping the value the host wrote, LBA0 0x01, LBA1 0x00 and LBA2 0x00. INTRQ stays low.
- R3: Any opcode other than 0x08, 0xA0 and 0xEF is aborted. So is 0xEF with a feature other than 0x03. An aborted command shows status 0x51 and error 0x04 (abort bit 2) and raises INTRQ.
- R4: Command 0xA0 gives status 0x58 and count 0x01 (command phase). LBA1 and LBA2 keep the byte count the host wrote, and INTRQ is low.
- R5: After the sixth data-port write of the command phase, status reads 0xD0 for BUSY_CYCLES clock cycles. INTRQ is low while the status is 0xD0.
- R6: The first packet after a reset ends with status 0x51, error 0x60 (sense key 6 in bits 7:4) and count 0x03, and raises INTRQ.
- R7: A later packet whose first byte (the low byte of the first word) is not 0x11 completes with status 0x50, error 0x00 and count 0x03, and raises INTRQ.
- R8: A later packet with first byte 0x11 enters data-in with status 0x58, error 0x00, count 0x02, LBA0 0x00 and LBA1 0x0C, and raises INTRQ. The registers stay the same until the last reply word is read.
- R9: The data port returns the reply bytes 00 B4 19 00 00 08 53 45 20 20 20 20. Each read carries two bytes, with the earlier byte in bits 7:0.
- R10: After the last reply word is read, status is 0xD0 with INTRQ low. The engine then completes with status 0x50, error 0x00, count 0x03 and LBA1 0x0C, and raises INTRQ.
- R11: Reading status (address 7) clears INTRQ. Reading the alternate status (address 8) returns the same value and changes nothing. Read data appears on the edge after the read strobe, and byte registers return 0x00 in bits 15:8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | 0 data, 1 error/feature, 2 count, 3 LBA0, 4 LBA1, 5 LBA2, 6 device, 7 status/command, 8 alternate status |
| bus_wdata | input | 16 | Write data (bits 7:0 for byte registers) |
| bus_rdata | output | 16 | Registered read data |
| intrq | output | 1 | Interrupt request to the host |

## Verification
The command decoder is swept over all 256 opcodes, which separates the three accepted commands from the abort path. SET FEATURES is tried with sixteen count values spread over the byte range, which shows the count is kept while the LBA registers are overwritten. Packets are sent with an all-zero body and with the 0x11 opcode, both straight after reset and after a unit-attention error has been consumed. This separates the error, the plain completion and the data-in path, and a reset command in the middle checks that unit attention is armed again. Status and alternate status reads are interleaved to tell the read that clears INTRQ from the one that does not.

// File: rtl/atapi_pkt_pkg.sv
package atapi_pkt_pkg;
  localparam logic [3:0] A_DATA    = 4'd0;
  localparam logic [3:0] A_ERRFEAT = 4'd1;
  localparam logic [3:0] A_COUNT   = 4'd2;
  localparam logic [3:0] A_LBA0    = 4'd3;
  localparam logic [3:0] A_LBA1    = 4'd4;
  localparam logic [3:0] A_LBA2    = 4'd5;
  localparam logic [3:0] A_DEV     = 4'd6;
  localparam logic [3:0] A_STATCMD = 4'd7;
  localparam logic [3:0] A_ALT     = 4'd8;

  localparam logic [7:0] OP_RESET  = 8'h08;
  localparam logic [7:0] OP_PACKET = 8'hA0;
  localparam logic [7:0] OP_SETFT  = 8'hEF;
  localparam logic [7:0] PKT_IDENT = 8'h11;

  localparam logic [7:0] ST_READY  = 8'h50;
  localparam logic [7:0] ST_ERROR  = 8'h51;
  localparam logic [7:0] ST_DRQ    = 8'h58;
  localparam logic [7:0] ST_BUSY   = 8'hD0;

  typedef enum logic [2:0] {
    PH_IDLE, PH_CMD, PH_BUSY_PKT, PH_DATA, PH_BUSY_DATA
  } phase_t;
endpackage

// File: rtl/atapi_reply_rom.sv
module atapi_reply_rom #(
  parameter int WORDS = 6,
  localparam int IW = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic [IW-1:0] idx,
  output logic [15:0]   word
);
  always_comb begin
    case (int'(idx))
      0:       word = 16'hB400;
      1:       word = 16'h0019;
      2:       word = 16'h0800;
      3:       word = 16'h4553;
      4:       word = 16'h2020;
      5:       word = 16'h2020;
      default: word = 16'hFFFF;
    endcase
  end
endmodule

// File: rtl/atapi_busy_timer.sv
module atapi_busy_timer #(
  parameter int CYCLES = 4,
  localparam int CW = $clog2(CYCLES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic done
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (load)         cnt_q <= CW'(CYCLES);
    else if (cnt_q != '0)  cnt_q <= cnt_q - CW'(1);
  end

  assign done = (cnt_q == CW'(1));
endmodule

// File: rtl/atapi_pkt_engine.sv
module atapi_pkt_engine
  import atapi_pkt_pkg::*;
#(
  parameter int BUSY_CYCLES = 4,
  parameter int PKT_WORDS   = 6,
  parameter int REPLY_WORDS = 6
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [3:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        intrq
);
  localparam int PW = $clog2(PKT_WORDS);
  localparam int RW = (REPLY_WORDS > 1) ? $clog2(REPLY_WORDS) : 1;

  phase_t        phase_q;
  logic [7:0]    stat_q, err_q, feat_q, cnt_q, lba0_q, lba1_q, lba2_q, dev_q, opcode_q;
  logic          unit_attn_q, irq_q;
  logic [PW-1:0] wcnt_q;
  logic [RW-1:0] ridx_q;
  logic [15:0]   reply_w, rd_val;
  logic          tmr_load, tmr_done, cmd_wr, data_wr, data_rd, last_wr, last_rd;

  assign cmd_wr  = bus_wr && bus_addr == A_STATCMD;
  assign data_wr = bus_wr && bus_addr == A_DATA && phase_q == PH_CMD;
  assign data_rd = bus_rd && bus_addr == A_DATA && phase_q == PH_DATA;
  assign last_wr = data_wr && wcnt_q == PW'(PKT_WORDS - 1);
  assign last_rd = data_rd && ridx_q == RW'(REPLY_WORDS - 1);
  assign tmr_load = last_wr || last_rd;

  atapi_reply_rom #(.WORDS(REPLY_WORDS)) u_rom (.idx(ridx_q), .word(reply_w));
  atapi_busy_timer #(.CYCLES(BUSY_CYCLES)) u_tmr (
    .clk(clk), .rst(rst), .load(tmr_load), .done(tmr_done));

  always_comb begin
    case (bus_addr)
      A_DATA:              rd_val = (phase_q == PH_DATA) ? reply_w : 16'hFFFF;
      A_ERRFEAT:           rd_val = {8'h00, err_q};
      A_COUNT:             rd_val = {8'h00, cnt_q};
      A_LBA0:              rd_val = {8'h00, lba0_q};
      A_LBA1:              rd_val = {8'h00, lba1_q};
      A_LBA2:              rd_val = {8'h00, lba2_q};
      A_DEV:               rd_val = {8'h00, dev_q};
      A_STATCMD, A_ALT:    rd_val = {8'h00, stat_q};
      default:             rd_val = 16'h0000;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      stat_q <= 8'h00; err_q <= 8'h01; cnt_q <= 8'h01; lba0_q <= 8'h01;
      lba1_q <= 8'h14; lba2_q <= 8'hEB; dev_q <= 8'h00; feat_q <= 8'h00;
      opcode_q <= 8'h00; unit_attn_q <= 1'b1; irq_q <= 1'b0;
      wcnt_q <= '0; ridx_q <= '0; bus_rdata <= 16'h0000;
    end else begin
      if (bus_rd) bus_rdata <= rd_val;
      if (bus_rd && bus_addr == A_STATCMD) irq_q <= 1'b0;

      if (phase_q == PH_IDLE && bus_wr) begin
        case (bus_addr)
          A_ERRFEAT: feat_q <= bus_wdata[7:0];
          A_COUNT:   cnt_q  <= bus_wdata[7:0];
          A_LBA0:    lba0_q <= bus_wdata[7:0];
          A_LBA1:    lba1_q <= bus_wdata[7:0];
          A_LBA2:    lba2_q <= bus_wdata[7:0];
          A_DEV:     dev_q  <= bus_wdata[7:0];
          default: ;
        endcase
      end

      if (cmd_wr && bus_wdata[7:0] == OP_RESET) begin
        phase_q <= PH_IDLE;
        stat_q <= 8'h00; err_q <= 8'h01; cnt_q <= 8'h01; lba0_q <= 8'h01;
        lba1_q <= 8'h14; lba2_q <= 8'hEB; dev_q <= 8'h00;
        unit_attn_q <= 1'b1; irq_q <= 1'b0;
      end else if (cmd_wr && phase_q == PH_IDLE) begin
        irq_q <= 1'b0;
        if (bus_wdata[7:0] == OP_PACKET) begin
          phase_q <= PH_CMD; stat_q <= ST_DRQ; cnt_q <= 8'h01; wcnt_q <= '0;
        end else if (bus_wdata[7:0] == OP_SETFT && feat_q == 8'h03) begin
          stat_q <= ST_READY; err_q <= 8'h00;
          lba0_q <= 8'h01; lba1_q <= 8'h00; lba2_q <= 8'h00;
        end else begin
          stat_q <= ST_ERROR; err_q <= 8'h04; irq_q <= 1'b1;
        end
      end

      if (data_wr) begin
        wcnt_q <= wcnt_q + PW'(1);
        if (wcnt_q == '0) opcode_q <= bus_wdata[7:0];
        if (last_wr) begin
          phase_q <= PH_BUSY_PKT; stat_q <= ST_BUSY;
        end
      end

      if (data_rd) begin
        ridx_q <= ridx_q + RW'(1);
        if (last_rd) begin
          phase_q <= PH_BUSY_DATA; stat_q <= ST_BUSY; irq_q <= 1'b0;
        end
      end

      if (tmr_done && phase_q == PH_BUSY_PKT) begin
        irq_q <= 1'b1;
        if (unit_attn_q) begin
          unit_attn_q <= 1'b0; phase_q <= PH_IDLE;
          stat_q <= ST_ERROR; err_q <= 8'h60; cnt_q <= 8'h03;
        end else if (opcode_q == PKT_IDENT) begin
          phase_q <= PH_DATA; ridx_q <= '0;
          stat_q <= ST_DRQ; err_q <= 8'h00; cnt_q <= 8'h02;
          lba0_q <= 8'h00; lba1_q <= 8'(2 * REPLY_WORDS);
        end else begin
          phase_q <= PH_IDLE;
          stat_q <= ST_READY; err_q <= 8'h00; cnt_q <= 8'h03;
        end
      end

      if (tmr_done && phase_q == PH_BUSY_DATA) begin
        irq_q <= 1'b1; phase_q <= PH_IDLE;
        stat_q <= ST_READY; err_q <= 8'h00; cnt_q <= 8'h03;
      end
    end
  end

  assign intrq = irq_q;
endmodule

// File: rtl/atapi_pkt_chk.sv
module atapi_pkt_chk
  import atapi_pkt_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic        bus_wr,
  input logic        bus_rd,
  input logic [3:0]  bus_addr,
  input logic [15:0] bus_wdata,
  input logic        intrq,
  input logic [7:0]  stat_q,
  input logic [7:0]  err_q,
  input logic [7:0]  cnt_q,
  input phase_t      phase_q
);
  // R1: reset command leaves the signature and no interrupt
  p_reset_sig_r1: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == A_STATCMD && bus_wdata[7:0] == OP_RESET)
      |=> (stat_q == 8'h00 && err_q == 8'h01 && !intrq));

  // R4: packet command opens the command phase quietly
  p_pkt_start_r4: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == A_STATCMD && bus_wdata[7:0] == OP_PACKET && phase_q == PH_IDLE)
      |=> (stat_q == ST_DRQ && cnt_q == 8'h01 && !intrq));

  // R5 / R10: no interrupt while busy
  p_busy_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    (stat_q == ST_BUSY) |-> !intrq);

  // R6 / R3: an error status carries one of the two error codes
  p_err_code_r6: assert property (@(posedge clk) disable iff (rst)
    (stat_q == ST_ERROR) |-> (err_q == 8'h60 || err_q == 8'h04));

  // R11: status read clears the interrupt outside busy periods
  p_stat_clear_r11: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !bus_wr && bus_addr == A_STATCMD &&
     phase_q != PH_BUSY_PKT && phase_q != PH_BUSY_DATA) |=> !intrq);

  // R11: alternate status read keeps a pending interrupt
  p_alt_keep_r11: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !bus_wr && bus_addr == A_ALT && intrq &&
     phase_q != PH_BUSY_PKT && phase_q != PH_BUSY_DATA) |=> intrq);
endmodule

bind atapi_pkt_engine atapi_pkt_chk u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .intrq(intrq), .stat_q(stat_q), .err_q(err_q),
  .cnt_q(cnt_q), .phase_q(phase_q));

// File: tb/sim_atapi_pkt_engine.sv
`timescale 1ns/1ps
module sim_atapi_pkt_engine;
  logic clk = 1'b0, rst = 1'b1, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0] bus_addr = 4'd0;
  logic [15:0] bus_wdata = 16'd0, bus_rdata;
  logic intrq;
  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  atapi_pkt_engine #(.BUSY_CYCLES(4)) u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .intrq(intrq));

  logic [7:0] reply_b [12] = '{8'h00, 8'hB4, 8'h19, 8'h00, 8'h00, 8'h08,
                               8'h53, 8'h45, 8'h20, 8'h20, 8'h20, 8'h20};

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic chk_reg(input string tag, input logic [3:0] a, input logic [7:0] exp);
    logic [15:0] v;
    rd(a, v);
    check(tag, v, {8'h00, exp});
  endtask

  task automatic chk_tf(input string tag, input logic [7:0] st, input logic [7:0] er,
                        input logic [7:0] ct, input logic [7:0] l0, input logic [7:0] l1,
                        input logic [7:0] l2);
    chk_reg({tag, " alt"}, 4'd8, st);
    chk_reg({tag, " err"}, 4'd1, er);
    chk_reg({tag, " cnt"}, 4'd2, ct);
    chk_reg({tag, " lba0"}, 4'd3, l0);
    chk_reg({tag, " lba1"}, 4'd4, l1);
    chk_reg({tag, " lba2"}, 4'd5, l2);
  endtask

  task automatic wait_ready();
    logic [15:0] v;
    for (int i = 0; i < 100; i++) begin
      rd(4'd8, v);
      if (!v[7]) return;
    end
    check("ready timeout", v, 16'h0050);
  endtask

  task automatic send_packet(input logic [15:0] pk [6]);
    logic [15:0] v;
    wr(4'd1, 16'h00); wr(4'd2, 16'h00); wr(4'd3, 16'h00);
    wr(4'd4, 16'h08); wr(4'd5, 16'h00); wr(4'd6, 16'h00);
    wr(4'd7, 16'hA0);
    chk_reg("R4 status", 4'd8, 8'h58);
    chk_reg("R4 count", 4'd2, 8'h01);
    chk_reg("R4 lba1", 4'd4, 8'h08);
    chk_reg("R4 lba2", 4'd5, 8'h00);
    check("R4 intrq", 16'(intrq), 16'h0);
    for (int i = 0; i < 6; i++) wr(4'd0, pk[i]);
    rd(4'd8, v);
    check("R5 busy", v, 16'h00D0);
    check("R5 intrq", 16'(intrq), 16'h0);
    wait_ready();
  endtask

  task automatic chk_signature(input string tag);
    logic [15:0] v;
    chk_tf(tag, 8'h00, 8'h01, 8'h01, 8'h01, 8'h14, 8'hEB);
    chk_reg({tag, " status"}, 4'd7, 8'h00);
    chk_reg({tag, " dev"}, 4'd6, 8'h00);
    rd(4'd0, v);
    check({tag, " data"}, v, 16'hFFFF);
    check({tag, " intrq"}, 16'(intrq), 16'h0);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      finish_run();
    end
  end

  initial begin
    logic [15:0] v;
    logic [15:0] zero_pk [6] = '{default: 16'h0000};
    logic [15:0] id_pk   [6] = '{16'h0011, 16'h0004, 16'h000C, 16'h0000, 16'h0000, 16'h0000};
    repeat (3) @(negedge clk);
    rst = 1'b0;

    chk_signature("R1 por");

    // R2: SET FEATURES sweep over count values
    for (int c = 0; c < 256; c += 17) begin
      wr(4'd1, 16'h03); wr(4'd2, 16'(c));
      wr(4'd3, 16'h09); wr(4'd4, 16'h09); wr(4'd5, 16'h09);
      wr(4'd7, 16'hEF);
      chk_tf("R2 setft", 8'h50, 8'h00, 8'(c), 8'h01, 8'h00, 8'h00);
      check("R2 intrq", 16'(intrq), 16'h0);
    end

    // R3: bad feature aborts; R11 alt vs status read
    wr(4'd1, 16'h05); wr(4'd7, 16'hEF);
    chk_reg("R3 ft alt", 4'd8, 8'h51);
    chk_reg("R3 ft err", 4'd1, 8'h04);
    check("R11 alt keeps intrq", 16'(intrq), 16'h1);
    chk_reg("R11 status same", 4'd7, 8'h51);
    check("R11 status clears", 16'(intrq), 16'h0);

    // R3: opcode sweep
    for (int op = 0; op < 256; op++) begin
      if (op == 8'h08 || op == 8'hA0 || op == 8'hEF) continue;
      wr(4'd7, 16'(op));
      chk_reg("R3 op alt", 4'd8, 8'h51);
      chk_reg("R3 op err", 4'd1, 8'h04);
      check("R3 op intrq", 16'(intrq), 16'h1);
      rd(4'd7, v);
    end

    // R6: first packet after reset fails
    send_packet(zero_pk);
    chk_tf("R6 ua", 8'h51, 8'h60, 8'h03, 8'h00, 8'h08, 8'h00);
    check("R6 intrq", 16'(intrq), 16'h1);
    rd(4'd7, v);

    // R7: second packet completes
    send_packet(zero_pk);
    chk_tf("R7 done", 8'h50, 8'h00, 8'h03, 8'h00, 8'h08, 8'h00);
    check("R7 intrq", 16'(intrq), 16'h1);
    rd(4'd7, v);

    // R8/R9/R10: identification packet
    send_packet(id_pk);
    chk_tf("R8 drq", 8'h58, 8'h00, 8'h02, 8'h00, 8'h0C, 8'h00);
    check("R8 intrq", 16'(intrq), 16'h1);
    chk_reg("R11 clear drq", 4'd7, 8'h58);
    check("R11 intrq low", 16'(intrq), 16'h0);
    for (int i = 0; i < 6; i++) begin
      rd(4'd0, v);
      check("R9 reply", v, {reply_b[2*i+1], reply_b[2*i]});
      if (i == 3) chk_tf("R8 hold", 8'h58, 8'h00, 8'h02, 8'h00, 8'h0C, 8'h00);
    end
    rd(4'd8, v);
    check("R10 busy", v, 16'h00D0);
    check("R10 busy intrq", 16'(intrq), 16'h0);
    wait_ready();
    chk_tf("R10 done", 8'h50, 8'h00, 8'h03, 8'h00, 8'h0C, 8'h00);
    check("R10 intrq", 16'(intrq), 16'h1);

    // R1: reset command; R6: unit attention re-armed
    wr(4'd7, 16'h08);
    chk_signature("R1 cmd");
    send_packet(zero_pk);
    chk_tf("R6 rearm", 8'h51, 8'h60, 8'h03, 8'h00, 8'h08, 8'h00);

    finished = 1;
    finish_run();
  end
endmodule